// File: doc/BRIEF.md
# Vector Fixed-Point Multiply Unit

This functional unit executes one multiply-group instruction at a time over a run of consecutive registers. A 32-bit instruction word carries the operand size, a post-multiply right shift, a rounding request, one of three modes, an element count and three 7-bit register numbers (first source A, first source B, first destination D). After accepting a word the unit steps through the elements one per clock. It reads A+i and B+i through two combinational register-file read ports and writes results through one write port.

The three modes are:
- **Elementwise product:** writes one result per element.
- **Dot product:** sums all full-width products and writes a single scaled result to D.
- **Scaled A plus B:** multiplies each A element by a scalar held in register 1 and adds the B element. The scalar is read once before the elements start.

Operands are signed two's complement. Register 0 always supplies zero when used as an operand.

The sequencer has four named states:
- **IDLE:** waiting for an instruction.
- **SCALAR:** fetching the scalar from register 1.
- **RUN:** one element per cycle.
- **DOTWB:** the single dot-product write-back.

The transitions are:
- **IDLE to SCALAR:** on accepting a scaled-A-plus-B word.
- **IDLE to RUN:** on accepting any other legal word.
- **SCALAR to RUN:** after one cycle.
- **RUN to RUN:** while the element index is below the count field.
- **RUN to DOTWB:** on the last element in dot mode.
- **RUN to IDLE:** on the last element otherwise.
- **DOTWB to IDLE:** after one cycle.

Top module: `vmul_unit`

## Requirements
- R1: The instruction fields are count = bits 27:24, A = bits 20:14, D = bits 13:7 and B = bits 6:0. The count field holds the number of elements minus one. Element i reads registers A+i and B+i and, in product modes, writes D+i, with addresses wrapping modulo 128.
- R2: Bits 31:28 select size and shift. Codes 0, 1 and 2 are 16x16 (signed low halves of A and B) with a right shift of 0, 8 and 16. Codes 4, 5 and 6 are 32x16 (all 32 bits of A signed, signed low half of B) with the same shifts. The shift is arithmetic and the low 32 bits are written.
- R3: When bit 23 is set, 2^(shift-1) is added before the shift. At shift 0 the rounding bit has no effect.
- R4: Bits 22:21 select the mode. Mode 0 writes scale(A_i x B_i) to D+i for every element.
- R5: Mode 1 (dot product) writes scale(sum over i of A_i x B_i) once to D, with rounding and shifting applied to the full sum.
- R6: Mode 2 writes scale(A_i x S) + B_i to D+i, where S is the signed low half of register 1 and B_i is added with its full 32 bits, modulo 2^32.
- R7: A register number 0 used as an operand reads as zero, whatever the register file returns.
- R8: busy rises in the cycle after acceptance and falls after the last write. For n elements, busy stays high for n cycles in mode 0 and n+1 cycles in modes 1 and 2.
- R9: insn_ready is low while busy, and a word presented while busy is not executed.
- R10: A word with bit 31 set, size bits 29:28 equal to 3, or mode equal to 3 is ignored: busy stays low and nothing is written.
- R11: During and after reset, busy is low, insn_ready is high and wr_en is low. Reset abandons any instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word present |
| insn_word | input | 32 | Multiply-group instruction |
| insn_ready | output | 1 | Unit can take an instruction |
| busy | output | 1 | Instruction in progress |
| rd_a_addr | output | 7 | Read port A register number |
| rd_a_data | input | 32 | Read port A data (combinational) |
| rd_b_addr | output | 7 | Read port B register number |
| rd_b_data | input | 32 | Read port B data (combinational) |
| wr_en | output | 1 | Write-back strobe |
| wr_addr | output | 7 | Write-back register number |
| wr_data | output | 32 | Write-back data |

## Verification
The hardest case to reach from the ports is a word presented during an instruction already in progress. Refusing such a word shows only as an absence, so the bench holds insn_valid high across two consecutive words. It then checks that the second destination keeps its fill pattern and that the write count matches the first word alone. Rounding on negative products is the other subtle case. Register contents are chosen so that truncation and rounding differ by one in both signs. The dot-product sum crosses a sign change between its elements, so scaling each element instead of the sum would give a different result.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int RADDR_W = 7;
    localparam int CNT_W   = 4;
    localparam int PROD_W  = DATA_W + HALF_W;
    localparam int ACC_W   = PROD_W + CNT_W + 4;
    localparam logic [RADDR_W-1:0] SCALAR_REG = RADDR_W'(1);

    typedef enum logic [1:0] {
        MD_MUL  = 2'd0,
        MD_DOT  = 2'd1,
        MD_SAXP = 2'd2,
        MD_BAD  = 2'd3
    } vmode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCALAR = 2'd1,
        ST_RUN    = 2'd2,
        ST_DOTWB  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic               wide;
        logic [1:0]         shsel;
        logic               rnd;
        vmode_e             mode;
        logic [CNT_W-1:0]   cnt;
        logic [RADDR_W-1:0] ra;
        logic [RADDR_W-1:0] rd;
        logic [RADDR_W-1:0] rb;
    } vinsn_t;

    // Optional half-LSB rounding, then arithmetic shift by 0, 8 or 16.
    function automatic logic [DATA_W-1:0] fx_scale(
        input logic signed [ACC_W-1:0] v,
        input logic [1:0]              shsel,
        input logic                    rnd
    );
        logic signed [ACC_W-1:0] t;
        t = v;
        unique case (shsel)
            2'd1: begin
                if (rnd) t = t + ACC_W'(128);
                t = t >>> 8;
            end
            2'd2: begin
                if (rnd) t = t + ACC_W'(32768);
                t = t >>> 16;
            end
            default: ;
        endcase
        return t[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/vmul_decode.sv
module vmul_decode
    import vmul_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output vinsn_t            fields,
    output logic              legal
);
    always_comb begin
        fields.wide  = word[30];
        fields.shsel = word[29:28];
        fields.cnt   = word[27:24];
        fields.rnd   = word[23];
        fields.mode  = vmode_e'(word[22:21]);
        fields.ra    = word[20:14];
        fields.rd    = word[13:7];
        fields.rb    = word[6:0];
        legal = !word[31] && (word[29:28] != 2'd3) && (word[22:21] != 2'd3);
    end
endmodule

// File: rtl/vmul_arith.sv
module vmul_arith
    import vmul_pkg::*;
(
    input  vinsn_t                   ins,
    input  logic [DATA_W-1:0]        a_val,
    input  logic [DATA_W-1:0]        b_val,
    input  logic [HALF_W-1:0]        s_val,
    input  logic signed [ACC_W-1:0]  acc,
    output logic signed [ACC_W-1:0]  prod,
    output logic [DATA_W-1:0]        elem_res,
    output logic [DATA_W-1:0]        dot_res
);
    logic [DATA_W-1:0]        a_op;
    logic [HALF_W-1:0]        m_op;
    logic signed [PROD_W-1:0] ax, mx, p;

    always_comb begin
        a_op = ins.wide ? a_val : {{HALF_W{a_val[HALF_W-1]}}, a_val[HALF_W-1:0]};
        m_op = (ins.mode == MD_SAXP) ? s_val : b_val[HALF_W-1:0];
        ax   = {{(PROD_W-DATA_W){a_op[DATA_W-1]}}, a_op};
        mx   = {{(PROD_W-HALF_W){m_op[HALF_W-1]}}, m_op};
        p    = ax * mx;
        prod = {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
        elem_res = fx_scale(prod, ins.shsel, ins.rnd)
                 + ((ins.mode == MD_SAXP) ? b_val : '0);
        dot_res  = fx_scale(acc, ins.shsel, ins.rnd);
    end
endmodule

// File: rtl/vmul_seq.sv
module vmul_seq
    import vmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  vmode_e           start_mode,
    input  vmode_e           cur_mode,
    input  logic [CNT_W-1:0] cur_cnt,
    output seq_state_e       state,
    output logic [CNT_W-1:0] idx
);
    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start)                     idx <= '0;
        else if (state == ST_RUN && idx != cur_cnt) idx <= idx + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = (start_mode == MD_SAXP) ? ST_SCALAR : ST_RUN;
            ST_SCALAR: nxt = ST_RUN;
            ST_RUN:    if (idx == cur_cnt) nxt = (cur_mode == MD_DOT) ? ST_DOTWB : ST_IDLE;
            ST_DOTWB:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/vmul_unit.sv
module vmul_unit
    import vmul_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_valid,
    input  logic [DATA_W-1:0]  insn_word,
    output logic               insn_ready,
    output logic               busy,
    output logic [RADDR_W-1:0] rd_a_addr,
    input  logic [DATA_W-1:0]  rd_a_data,
    output logic [RADDR_W-1:0] rd_b_addr,
    input  logic [DATA_W-1:0]  rd_b_data,
    output logic               wr_en,
    output logic [RADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data
);
    vinsn_t                  dec_f, cur;
    logic                    dec_legal, accept;
    seq_state_e              state;
    logic [CNT_W-1:0]        idx;
    logic [HALF_W-1:0]       s_reg;
    logic signed [ACC_W-1:0] acc, prod;
    logic [DATA_W-1:0]       a_eff, b_eff, elem_res, dot_res;

    vmul_decode u_dec (.word(insn_word), .fields(dec_f), .legal(dec_legal));

    vmul_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .start_mode(dec_f.mode),
        .cur_mode(cur.mode), .cur_cnt(cur.cnt), .state(state), .idx(idx)
    );

    vmul_arith u_arith (
        .ins(cur), .a_val(a_eff), .b_val(b_eff), .s_val(s_reg), .acc(acc),
        .prod(prod), .elem_res(elem_res), .dot_res(dot_res)
    );

    assign accept = insn_valid && !busy && dec_legal;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            s_reg <= '0;
            acc   <= '0;
        end else begin
            if (accept) begin
                cur <= dec_f;
                acc <= '0;
            end
            if (state == ST_SCALAR) s_reg <= a_eff[HALF_W-1:0];
            if (state == ST_RUN && cur.mode == MD_DOT) acc <= acc + prod;
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        insn_ready = !busy;
        rd_a_addr  = (state == ST_SCALAR) ? SCALAR_REG : cur.ra + RADDR_W'(idx);
        rd_b_addr  = cur.rb + RADDR_W'(idx);
        a_eff      = (rd_a_addr == '0) ? '0 : rd_a_data;
        b_eff      = (rd_b_addr == '0) ? '0 : rd_b_data;
        wr_en      = (state == ST_RUN && cur.mode != MD_DOT) || (state == ST_DOTWB);
        wr_addr    = (state == ST_DOTWB) ? cur.rd : cur.rd + RADDR_W'(idx);
        wr_data    = (state == ST_DOTWB) ? dot_res : elem_res;
    end
endmodule

// File: rtl/vmul_unit_chk.sv
module vmul_unit_chk
    import vmul_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               insn_valid,
    input logic               busy,
    input logic               wr_en,
    input logic [RADDR_W-1:0] wr_addr
);
    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R8

    AST_BUSY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_valid)); // R9

    AST_BUSY_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_en)); // R8

    AST_CONSEC_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + RADDR_W'(1))); // R1
endmodule

bind vmul_unit vmul_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/vmul_unit_tb_top.sv
module vmul_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        insn_ready, busy, wr_en;
    logic [6:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic [31:0] rf [128];
    logic        do_init = 1'b0;
    int          wr_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    localparam logic [31:0] FILL = 32'hAAAA_AAAA;

    always #2.5 clk = ~clk;

    vmul_unit dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .insn_ready(insn_ready), .busy(busy),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign rd_a_data = rf[rd_a_addr];
    assign rd_b_data = rf[rd_b_addr];

    function automatic logic [31:0] init_val(input int k);
        case (k)
            0: return 32'h0000_1234;
            1: return 32'h0000_0003;
            2: return 32'h0000_0100;
            3: return 32'h0000_0200;
            4: return 32'h0000_FFFE;
            5: return 32'h0000_0181;
            6: return 32'h0001_0000;
            7: return 32'h0000_0007;
            default: return FILL;
        endcase
    endfunction

    always @(posedge clk) begin
        if (do_init) begin
            for (int k = 0; k < 128; k++) rf[k] <= init_val(k);
        end else if (wr_en) begin
            rf[wr_addr] <= wr_data;
        end
        if (wr_en) wr_cnt <= wr_cnt + 1;
    end

    function automatic logic [31:0] mk(input logic [3:0] sz, input logic rnd,
        input logic [1:0] md, input logic [3:0] cnt,
        input logic [6:0] a, input logic [6:0] d, input logic [6:0] b);
        return {sz, cnt, rnd, md, a, d, b};
    endfunction

    typedef struct packed {
        logic [31:0] insn;
        logic [31:0] exp;
        logic [7:0]  cyc;
    } vec_t;

    // Single-result vectors, destination R20.
    localparam vec_t VEC [17] = '{
        '{mk(4'h0,1'b0,2'd0,4'd0,7'd2,7'd20,7'd3), 32'h0002_0000, 8'd1}, // R2 R4 256*512
        '{mk(4'h1,1'b0,2'd0,4'd0,7'd2,7'd20,7'd3), 32'h0000_0200, 8'd1}, // R2 sr8
        '{mk(4'h2,1'b0,2'd0,4'd0,7'd2,7'd20,7'd3), 32'h0000_0002, 8'd1}, // R2 sr16
        '{mk(4'h0,1'b0,2'd0,4'd0,7'd4,7'd20,7'd2), 32'hFFFF_FE00, 8'd1}, // R2 signed -2*256
        '{mk(4'h1,1'b0,2'd0,4'd0,7'd5,7'd20,7'd7), 32'h0000_000A, 8'd1}, // R3 trunc 2695>>8
        '{mk(4'h1,1'b1,2'd0,4'd0,7'd5,7'd20,7'd7), 32'h0000_000B, 8'd1}, // R3 rounded
        '{mk(4'h0,1'b1,2'd0,4'd0,7'd5,7'd20,7'd7), 32'h0000_0A87, 8'd1}, // R3 no effect at shift 0
        '{mk(4'h4,1'b0,2'd0,4'd0,7'd6,7'd20,7'd7), 32'h0007_0000, 8'd1}, // R2 32x16
        '{mk(4'h6,1'b0,2'd0,4'd0,7'd6,7'd20,7'd7), 32'h0000_0007, 8'd1}, // R2 32x16 sr16
        '{mk(4'h0,1'b0,2'd0,4'd0,7'd6,7'd20,7'd7), 32'h0000_0000, 8'd1}, // R2 16x16 drops A high half
        '{mk(4'h0,1'b0,2'd0,4'd0,7'd0,7'd20,7'd7), 32'h0000_0000, 8'd1}, // R7 A=R0
        '{mk(4'h1,1'b1,2'd0,4'd0,7'd4,7'd20,7'd5), 32'hFFFF_FFFD, 8'd1}, // R3 negative rounded
        '{mk(4'h1,1'b0,2'd0,4'd0,7'd4,7'd20,7'd5), 32'hFFFF_FFFC, 8'd1}, // R3 negative trunc
        '{mk(4'h0,1'b0,2'd2,4'd0,7'd2,7'd20,7'd3), 32'h0000_0500, 8'd2}, // R6 256*3+512
        '{mk(4'h1,1'b1,2'd2,4'd0,7'd5,7'd20,7'd7), 32'h0000_000C, 8'd2}, // R6 rnd(1155)+7
        '{mk(4'h0,1'b0,2'd1,4'd1,7'd2,7'd20,7'd4), 32'h0003_0000, 8'd3}, // R5 -512+197120
        '{mk(4'h2,1'b0,2'd1,4'd1,7'd2,7'd20,7'd4), 32'h0000_0003, 8'd3}  // R5 sum then sr16
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic init_regs();
        @(negedge clk) do_init = 1'b1;
        @(negedge clk) do_init = 1'b0;
    endtask

    task automatic run(input logic [31:0] w, output int cyc, output int nw);
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = w;
        @(negedge clk);
        insn_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 64) begin
            cyc++;
            @(negedge clk);
        end
        nw = wr_cnt - w0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int cyc, nw;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy in reset", {31'd0, busy}, 32'd0);
        chk("R11 ready in reset", {31'd0, insn_ready}, 32'd1);
        chk("R11 wr_en in reset", {31'd0, wr_en}, 32'd0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            init_regs();
            run(VEC[i].insn, cyc, nw);
            chk($sformatf("R4 vec%0d result", i), rf[20], VEC[i].exp);
            chk($sformatf("R8 vec%0d busy", i), cyc, 32'(VEC[i].cyc));
            chk($sformatf("R5 vec%0d writes", i), nw, 32'd1);
        end

        // R1 R4 four elements, consecutive registers
        init_regs();
        run(mk(4'h0,1'b0,2'd0,4'd3,7'd2,7'd30,7'd4), cyc, nw);
        chk("R1 elem0", rf[30], 32'hFFFF_FE00);
        chk("R1 elem1", rf[31], 32'h0003_0200);
        chk("R1 elem2", rf[32], 32'h0000_0000);
        chk("R1 elem3", rf[33], 32'h0000_0A87);
        chk("R1 past end", rf[34], FILL);
        chk("R8 busy n=4", cyc, 32'd4);
        chk("R1 writes n=4", nw, 32'd4);

        // R6 two elements with scalar
        init_regs();
        run(mk(4'h0,1'b0,2'd2,4'd1,7'd2,7'd40,7'd4), cyc, nw);
        chk("R6 elem0", rf[40], 32'h0001_02FE);
        chk("R6 elem1", rf[41], 32'h0000_0781);
        chk("R8 saxp busy n+1", cyc, 32'd3);

        // R9 word presented while busy is refused
        init_regs();
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = mk(4'h0,1'b0,2'd0,4'd7,7'd2,7'd50,7'd3);
        begin
            int w0;
            w0 = wr_cnt;
            @(negedge clk);
            insn_word = mk(4'h0,1'b0,2'd0,4'd0,7'd2,7'd60,7'd3);
            chk("R9 ready low while busy", {31'd0, insn_ready}, 32'd0);
            @(negedge clk);
            insn_valid = 1'b0;
            cyc = 0;
            while (busy && cyc < 64) begin
                cyc++;
                @(negedge clk);
            end
            repeat (2) @(negedge clk);
            chk("R9 refused dest untouched", rf[60], FILL);
            chk("R9 writes only first", wr_cnt - w0, 32'd8);
        end

        // R10 illegal encodings ignored
        init_regs();
        run(mk(4'h3,1'b0,2'd0,4'd0,7'd2,7'd20,7'd3), cyc, nw);
        chk("R10 size3 busy", cyc, 32'd0);
        chk("R10 size3 writes", nw, 32'd0);
        run(mk(4'h0,1'b0,2'd3,4'd0,7'd2,7'd20,7'd3), cyc, nw);
        chk("R10 mode3 busy", cyc, 32'd0);
        run(mk(4'h8,1'b0,2'd0,4'd0,7'd2,7'd20,7'd3), cyc, nw);
        chk("R10 bit31 busy", cyc, 32'd0);
        chk("R10 dest untouched", rf[20], FILL);

        // R11 reset abandons work in progress
        init_regs();
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = mk(4'h0,1'b0,2'd0,4'd9,7'd2,7'd70,7'd3);
        @(negedge clk);
        insn_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 busy after reset", {31'd0, busy}, 32'd0);
        chk("R11 wr_en after reset", {31'd0, wr_en}, 32'd0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R11 no resume", rf[75], FILL);

        finish_run();
    end
endmodule